// File: doc/BRIEF.md
# Queue Buffer with Offset Peek Port

This block is a single-clock first-in-first-out store for data words. Word width and capacity are compile-time parameters. A producer writes words at the tail with a write enable. A consumer takes words from the head with a read enable, and the popped word appears on a registered output one cycle later. A push and a pop may be issued in the same cycle.

The block reports its fill state through several outputs: an occupancy count, empty, full and half-full flags, and a threshold flag. The threshold flag compares the count against a value that software or neighbouring logic supplies at run time. A second read port looks inside the queue. It takes an offset measured from the current head and returns the word stored there one cycle later. This read leaves the queue contents and pointers unchanged. Requests that cannot be honoured are dropped, and each dropped request is reported as a one-cycle error pulse.

Internally, a small state machine tracks whether the queue is empty, partly filled or full, and decides which requests to accept. A datapath holds the storage, the head and tail pointers, the count and the output registers.

Top module: `qbuf_peek`

## Requirements
- R1: While `rst` is high at a clock edge, the queue is emptied: after that edge `empty`=1, `full`=0, `level`=0, `half_full`=0, and `rd_data`, `peek_data`, `ovf_err` and `udf_err` are all 0.
- R2: Words leave in the order they were accepted. After an edge that accepts a pop, `rd_data` holds the oldest stored word.
- R3: `level` equals the number of stored words. An accepted push adds one, and an accepted pop removes one. When both are accepted in the same cycle, `level` does not change.
- R4: `empty` is 1 exactly when `level`=0, and `full` is 1 exactly when `level`=DEPTH.
- R5: `half_full` is 1 exactly when `level` >= DEPTH/2.
- R6: `at_thresh` is 1 exactly when `level` >= `thresh`. With `thresh`=0 it is always 1.
- R7: A push while full, without a pop in the same cycle, is ignored: the queue does not change, and `ovf_err` is 1 for the one cycle after that edge.
- R8: A pop while empty is ignored: the queue does not change, `rd_data` keeps its value, and `udf_err` is 1 for the one cycle after that edge. `rd_data` changes only after an accepted pop.
- R9: When the queue is full, a push and a pop in the same cycle are both accepted. `level` stays at DEPTH, and the pushed word becomes the newest entry.
- R10: When the queue is empty, a push and a pop in the same cycle perform only the push. `level` becomes 1, and `udf_err` pulses.
- R11: After each edge, `peek_data` holds the word at offset `peek_off` from the head, as the queue stood before that edge. Offset 0 is the oldest word. A peek does not change the queue.
- R12: If `peek_off` >= `level` before the edge, then after the edge `peek_data` is 0 and `peek_bad` is 1. Otherwise `peek_bad` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push request |
| wr_data | input | DW | Word to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | DW | Last popped word, registered |
| thresh | input | CW | Occupancy threshold for `at_thresh` |
| peek_off | input | CW | Offset from head for the peek port |
| peek_data | output | DW | Word at the peek offset, registered |
| peek_bad | output | 1 | Peek offset was outside the stored words |
| level | output | CW | Number of stored words |
| empty | output | 1 | Queue holds no words |
| full | output | 1 | Queue holds DEPTH words |
| half_full | output | 1 | Level at or above half capacity |
| at_thresh | output | 1 | Level at or above `thresh` |
| ovf_err | output | 1 | One-cycle pulse: a push was dropped |
| udf_err | output | 1 | One-cycle pulse: a pop was dropped |

## Verification
If the controller state and the datapath count disagree, the error reaches the ports at the very next edge. It appears as `empty` or `full` contradicting `level`, or as a request being dropped or accepted wrongly, which shows up as a missing or spurious error pulse. A corrupted head or tail pointer stays hidden until the affected slot is read. The bench therefore peeks at every offset on idle cycles and compares every popped word against a reference queue, so that wrong ordering is caught within one cycle of the read. Wrap-around bugs appear only after the pointers pass the last slot. For that reason the stimulus fills and drains the queue repeatedly and runs a long mixed push/pop stream.

// File: rtl/qbuf_pkg.sv
package qbuf_pkg;
  typedef enum logic [1:0] {
    QS_EMPTY = 2'd0,
    QS_MID   = 2'd1,
    QS_FULL  = 2'd2
  } qstate_t;
endpackage

// File: rtl/qbuf_ctrl.sv
module qbuf_ctrl
  import qbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [CW-1:0] level,
  output logic          do_push,
  output logic          do_pop,
  output logic          is_empty,
  output logic          is_full,
  output logic          ovf_err,
  output logic          udf_err
);
  localparam logic [CW-1:0] LVL_ONE  = CW'(1);
  localparam logic [CW-1:0] LVL_LAST = CW'(DEPTH - 1);

  qstate_t state, state_nxt;

  // Acceptance decision: depends only on the registered state
  always_comb begin
    do_push = 1'b0;
    do_pop  = 1'b0;
    unique case (state)
      QS_EMPTY: do_push = wr_en;
      QS_MID: begin
        do_push = wr_en;
        do_pop  = rd_en;
      end
      QS_FULL: begin
        do_pop  = rd_en;
        do_push = wr_en & rd_en;
      end
      default: ;
    endcase
  end

  always_comb begin
    state_nxt = state;
    if (do_push && !do_pop)
      state_nxt = (level == LVL_LAST) ? QS_FULL : QS_MID;
    else if (do_pop && !do_push)
      state_nxt = (level == LVL_ONE) ? QS_EMPTY : QS_MID;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= QS_EMPTY;
      ovf_err <= 1'b0;
      udf_err <= 1'b0;
    end else begin
      state   <= state_nxt;
      ovf_err <= wr_en & ~do_push;
      udf_err <= rd_en & ~do_pop;
    end
  end

  assign is_empty = (state == QS_EMPTY);
  assign is_full  = (state == QS_FULL);

  AST_EMPTY_LEVEL: assert property (@(posedge clk) disable iff (rst)
    is_empty == (level == '0)); // R4
  AST_FULL_LEVEL: assert property (@(posedge clk) disable iff (rst)
    is_full == (level == CW'(DEPTH))); // R4
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |-> !do_pop); // R8
endmodule

// File: rtl/qbuf_store.sv
module qbuf_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wr_data,
  input  logic [CW-1:0] peek_off,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] peek_data,
  output logic          peek_bad,
  output logic [CW-1:0] level
);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   SPAN     = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] head, tail, paddr;
  logic [AW:0]   psum;
  logic          pvalid;

  // Storage: plain synchronous write, no reset, so it maps to RAM
  always_ff @(posedge clk) begin
    if (push) mem[tail] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      level <= '0;
    end else begin
      if (push) tail <= (tail == PTR_LAST) ? '0 : tail + AW'(1);
      if (pop)  head <= (head == PTR_LAST) ? '0 : head + AW'(1);
      unique case ({push, pop})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: ;
      endcase
    end
  end

  // Peek address: head plus offset, modulo DEPTH
  always_comb begin
    psum   = {1'b0, head} + (AW+1)'(peek_off);
    if (psum >= SPAN) psum = psum - SPAN;
    paddr  = psum[AW-1:0];
    pvalid = (peek_off < level);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      peek_data <= '0;
      peek_bad  <= 1'b0;
    end else begin
      if (pop) rd_data <= mem[head];
      peek_data <= pvalid ? mem[paddr] : '0;
      peek_bad  <= ~pvalid;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH)); // R3
  AST_PAIR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> (level == $past(level))); // R3
endmodule

// File: rtl/qbuf_peek.sv
module qbuf_peek #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic [CW-1:0] thresh,
  input  logic [CW-1:0] peek_off,
  output logic [DW-1:0] peek_data,
  output logic          peek_bad,
  output logic [CW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          half_full,
  output logic          at_thresh,
  output logic          ovf_err,
  output logic          udf_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  logic do_push, do_pop;

  qbuf_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .level    (level),
    .do_push  (do_push),
    .do_pop   (do_pop),
    .is_empty (empty),
    .is_full  (full),
    .ovf_err  (ovf_err),
    .udf_err  (udf_err)
  );

  qbuf_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .push      (do_push),
    .pop       (do_pop),
    .wr_data   (wr_data),
    .peek_off  (peek_off),
    .rd_data   (rd_data),
    .peek_data (peek_data),
    .peek_bad  (peek_bad),
    .level     (level)
  );

  assign half_full = (level >= HALF);
  assign at_thresh = (level >= thresh);

  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> ovf_err); // R7
  AST_UDF_PULSE: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> udf_err); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && !empty) |=> $stable(rd_data)); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(empty && full)); // R4
  AST_FULL_HALF: assert property (@(posedge clk) disable iff (rst)
    full |-> half_full); // R5
  AST_PEEK_ZERO: assert property (@(posedge clk) disable iff (rst)
    peek_bad |-> (peek_data == '0)); // R12
  AST_FULL_PAIR: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && rd_en) |=> (full && !ovf_err)); // R9
endmodule

// File: tb/sim_qbuf_peek.sv
`timescale 1ns/1ps
module sim_qbuf_peek;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [CW-1:0] thresh = '0, peek_off = '0;
  logic [DW-1:0] rd_data, peek_data;
  logic [CW-1:0] level;
  logic          peek_bad, empty, full, half_full, at_thresh, ovf_err, udf_err;

  qbuf_peek #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .thresh(thresh), .peek_off(peek_off),
    .peek_data(peek_data), .peek_bad(peek_bad), .level(level),
    .empty(empty), .full(full), .half_full(half_full), .at_thresh(at_thresh),
    .ovf_err(ovf_err), .udf_err(udf_err)
  );

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] mq[$];
  logic [DW-1:0] sb[$];
  bit            pop_acc = 1'b0;
  logic [DW-1:0] last_rd = '0;
  int            th_v = 0, po_v = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: compares each popped word with the scoreboard
  always @(posedge clk) begin
    bit fire;
    logic [DW-1:0] e;
    fire = pop_acc;
    #2;
    if (fire) begin
      e = sb.pop_front();
      chk("R2 pop order", int'(rd_data), int'(e));
      last_rd = e;
    end
  end

  // Driver: applies one cycle of stimulus, updates the model, checks flags
  task automatic step(input bit w, input logic [DW-1:0] d, input bit r);
    int cur;
    bit pok, wok, pbad;
    logic [DW-1:0] pexp;
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r;
    thresh = CW'(th_v); peek_off = CW'(po_v);
    cur  = mq.size();
    pok  = r && (cur > 0);
    wok  = w && ((cur < DEPTH) || pok);
    if (po_v < cur) begin pexp = mq[po_v]; pbad = 1'b0; end
    else begin pexp = '0; pbad = 1'b1; end
    pop_acc = pok;
    if (pok) sb.push_back(mq.pop_front());
    if (wok) mq.push_back(d);
    @(posedge clk);
    #1;
    pop_acc = 1'b0;
    chk("R3 level", int'(level), mq.size());
    chk("R4 empty", int'(empty), int'(mq.size() == 0));
    chk("R4 full", int'(full), int'(mq.size() == DEPTH));
    chk("R5 half_full", int'(half_full), int'(mq.size() >= DEPTH / 2));
    chk("R6 at_thresh", int'(at_thresh), int'(mq.size() >= th_v));
    chk("R7 ovf_err", int'(ovf_err), int'(w && !wok));
    chk("R8 udf_err", int'(udf_err), int'(r && !pok));
    chk("R11 peek_data", int'(peek_data), int'(pexp));
    chk("R12 peek_bad", int'(peek_bad), int'(pbad));
    if (!pok) chk("R8 rd_data hold", int'(rd_data), int'(last_rd));
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    th_v = 4; po_v = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 level", int'(level), 0);
    chk("R1 half_full", int'(half_full), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 peek_data", int'(peek_data), 0);
    chk("R1 errors", int'(ovf_err | udf_err), 0);
    rst = 1'b0;

    // Push five words, peeking in between (R11)
    for (int i = 0; i < 5; i++) begin
      po_v = i / 2;
      step(1'b1, DW'(8'h10 + i), 1'b0);
    end
    // Peek sweep on idle cycles, including out-of-range offsets (R11, R12)
    for (int o = 0; o < 8; o++) begin
      po_v = o;
      step(1'b0, '0, 1'b0);
    end
    chk("R11 queue untouched", int'(level), 5);
    po_v = 0;
    // Pop two (R2)
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b1);
    // Fill past capacity: overflow drops (R7)
    for (int i = 0; i < DEPTH + 3; i++) step(1'b1, DW'(8'h40 + i), 1'b0);
    chk("R7 level stays full", int'(level), DEPTH);
    // Full with push and pop together (R9)
    step(1'b1, 8'hAA, 1'b1);
    chk("R9 level", int'(level), DEPTH);
    chk("R9 no overflow", int'(ovf_err), 0);
    po_v = DEPTH - 1;
    step(1'b0, '0, 1'b0);
    chk("R9 newest word", int'(peek_data), 32'hAA);
    // Threshold corners (R6)
    th_v = 0;          step(1'b0, '0, 1'b0);
    th_v = DEPTH;      step(1'b0, '0, 1'b0);
    th_v = DEPTH + 1;  step(1'b0, '0, 1'b0);
    chk("R6 above level", int'(at_thresh), 0);
    // Drain past empty: underflow drops (R8)
    po_v = 0; th_v = 3;
    for (int i = 0; i < DEPTH + 3; i++) step(1'b0, '0, 1'b1);
    // Empty with push and pop together (R10)
    step(1'b1, 8'h55, 1'b1);
    chk("R10 level", int'(level), 1);
    chk("R10 udf pulse", int'(udf_err), 1);
    step(1'b0, '0, 1'b1);
    // Mixed stream with wrap-around
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      th_v = int'(lfsr[4:0]) % (DEPTH + 2);
      po_v = int'(lfsr[12:8]) % (DEPTH + 2);
      step(lfsr[0] | lfsr[5], lfsr[15:8], lfsr[1] & (i > 300 || lfsr[6]));
    end
    step(1'b0, '0, 1'b0);
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule